// File: doc/BRIEF.md
# Zero-Fill Stream-to-Buffer Adapter

This block connects a valid/ready packet stream to a write engine that has one firm rule: each transfer must produce exactly the number of beats that was asked for. A transfer request names a length in beats and carries a final-buffer flag. The adapter then passes input beats straight to its output. If the input packet ends before the length is used up, the adapter makes all-zero beats until the transfer is complete. While it does this, it refuses further input.

A request is taken only while the adapter is idle. A single down-counter tracks the beats still owed to the output. Forwarded beats and zero beats both decrement it. When the counter reaches its last beat, the transfer ends. This happens whether or not the packet is finished, and any rest of that packet becomes the start of the next transfer. A single-cycle completion pulse marks the final output beat and repeats the request's final-buffer flag.

Back-pressure rules:
- On the output side a beat moves only in a cycle where `out_valid` and `out_ready` are both high.
- On the input side a beat is consumed only in a cycle where `in_valid` and `in_ready` are both high.
- While forwarding, `in_ready` follows `out_ready` combinationally, so a stalled consumer stalls the producer in the same cycle.
- The input source must hold a presented beat until it is consumed.

Top module: `zfill_stream_adapter`

## Requirements
- R1: While idle, `req_ready` is 1, `in_ready` is 0 and `out_valid` is 0. A request with `req_len` = 0 is consumed and ignored: the block stays idle.
- R2: While forwarding, `out_valid` equals `in_valid`, `out_data` equals `in_data` and `in_ready` equals `out_ready`.
- R3: When an input beat with `in_last` = 1 is forwarded and it is not the transfer's final beat, the block enters zero fill. There `out_valid` is 1 and `out_data` is 0 until the transfer completes.
- R4: During zero fill `in_ready` stays 0, so no input beat is consumed.
- R5: When `in_last` arrives on the transfer's final beat, no zero beats are produced and the block is idle in the next cycle.
- R6: When the length runs out before `in_last`, the transfer completes. The remaining beats of that packet are forwarded as the first beats of the next transfer.
- R7: Each accepted non-zero request produces exactly `req_len` output handshakes. `done_pulse` is 1 in exactly the cycle of the last of them.
- R8: `done_final` equals the accepted request's `req_final` bit in the cycle of `done_pulse`, and is 0 in every other cycle.
- R9: Synchronous active-high `rst` returns the block to idle, with `in_ready`, `out_valid` and `done_pulse` low, even in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Request accepted this cycle (idle) |
| req_len | input | LEN_W | Transfer length in beats |
| req_final | input | 1 | This transfer closes the buffer |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat consumed when valid |
| in_data | input | DATA_W | Input beat payload |
| in_last | input | 1 | Input beat ends its packet |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts a beat |
| out_data | output | DATA_W | Output payload (zero while filling) |
| done_pulse | output | 1 | Final beat of the transfer handshakes now |
| done_final | output | 1 | Final-buffer flag of the completing transfer |

## Verification
`req_ready`, `in_ready`, `out_valid`, `out_data` and `done_pulse` are combinational in the current state and the current inputs. They are due in the same cycle as the stimulus. State changes caused by a handshake show up one clock later.

The bench drives inputs just after the rising edge and compares every output against its behavioural model at the falling edge, before any state moves. It advances the model only after that comparison. Per-scenario counts of zero-fill beats and completion pulses confirm the padding, truncation and no-padding cases.

// File: rtl/zfill_pkg.sv
package zfill_pkg;
  typedef enum logic [1:0] {
    ZF_IDLE = 2'd0,
    ZF_PASS = 2'd1,
    ZF_PAD  = 2'd2
  } zf_state_e;
endpackage

// File: rtl/zfill_beat_cnt.sv
module zfill_beat_cnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             at_final
);
  logic [LEN_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) remain_q <= '0;
    else if (load) remain_q <= load_val;
    else if (dec) remain_q <= remain_q - 1'b1;
  end

  assign at_final = (remain_q == {{(LEN_W-1){1'b0}}, 1'b1});

  // R7
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    dec |-> remain_q != '0);
endmodule

// File: rtl/zfill_ctrl.sv
module zfill_ctrl
  import zfill_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      req_valid,
  input  logic      req_nonzero,
  input  logic      req_final,
  input  logic      beat_fire,
  input  logic      in_last,
  input  logic      at_final,
  output zf_state_e state,
  output logic      load,
  output logic      final_flag
);
  zf_state_e state_q, state_d;
  logic flag_q;

  assign load = (state_q == ZF_IDLE) && req_valid && req_nonzero;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ZF_IDLE: if (load) state_d = ZF_PASS;
      ZF_PASS: if (beat_fire) begin
        if (at_final) state_d = ZF_IDLE;
        else if (in_last) state_d = ZF_PAD;
      end
      ZF_PAD:  if (beat_fire && at_final) state_d = ZF_IDLE;
      default: state_d = ZF_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ZF_IDLE;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load) flag_q <= req_final;
    end
  end

  assign state      = state_q;
  assign final_flag = flag_q;

  // R9
  rst_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> state_q == ZF_IDLE);
  // R5
  last_on_final_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ZF_PASS && beat_fire && at_final && in_last) |=> state_q == ZF_IDLE);
  // R3
  pad_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ZF_PASS && beat_fire && !at_final && in_last) |=> state_q == ZF_PAD);
endmodule

// File: rtl/zfill_out_mux.sv
module zfill_out_mux
  import zfill_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  zf_state_e         state,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = '0;
    unique case (state)
      ZF_PASS: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
      end
      ZF_PAD:  out_valid = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/zfill_stream_adapter.sv
module zfill_stream_adapter
  import zfill_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_final,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              done_pulse,
  output logic              done_final
);
  zf_state_e cur_state;
  logic load, at_final, final_flag, beat_fire;

  assign beat_fire = out_valid && out_ready;
  assign req_ready = (cur_state == ZF_IDLE);

  zfill_ctrl ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_nonzero (req_len != '0),
    .req_final   (req_final),
    .beat_fire   (beat_fire),
    .in_last     (in_last),
    .at_final    (at_final),
    .state       (cur_state),
    .load        (load),
    .final_flag  (final_flag)
  );

  zfill_beat_cnt #(.LEN_W(LEN_W)) cnt_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (req_len),
    .dec      (beat_fire),
    .at_final (at_final)
  );

  zfill_out_mux #(.DATA_W(DATA_W)) mux_i (
    .state     (cur_state),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  assign done_pulse = beat_fire && at_final;
  assign done_final = done_pulse && final_flag;

  // R4
  pad_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_state == ZF_PAD) |-> !in_ready);
  // R3
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !in_valid) |-> out_data == '0);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!out_valid && !in_ready));
  // R7
  done_hs_chk: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> (out_valid && out_ready));
  // R7
  done_ends_chk: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> req_ready);
  // R8
  final_gate_chk: assert property (@(posedge clk) disable iff (rst)
    done_final |-> done_pulse);
endmodule

// File: tb/zfill_stream_adapter_tb_top.sv
`timescale 1ns/1ps
module zfill_stream_adapter_tb_top;
  localparam int DW = 16;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_final = 1'b0;
  logic [LW-1:0] req_len = '0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic req_ready, in_ready, out_valid, done_pulse, done_final;
  logic [DW-1:0] out_data;

  always #2 clk = ~clk;

  zfill_stream_adapter #(.DATA_W(DW), .LEN_W(LW)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_len(req_len), .req_final(req_final),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done_pulse(done_pulse), .done_final(done_final)
  );

  int total = 0, bad = 0;
  int req_len_q[$];
  bit req_fin_q[$];
  logic [DW:0] beat_q[$];
  int m_st = 0, m_left = 0;
  bit m_flag = 0;
  int pad_cnt = 0, done_cnt = 0;
  bit stalled = 0;

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic push_pkt(int n, int base);
    for (int i = 0; i < n; i++) beat_q.push_back({(i == n-1), DW'(base + i)});
  endtask

  task automatic push_req(int len, bit fin);
    req_len_q.push_back(len);
    req_fin_q.push_back(fin);
  endtask

  task automatic model_reset();
    m_st = 0; m_left = 0; m_flag = 0; stalled = 0;
    req_len_q.delete(); req_fin_q.delete(); beat_q.delete();
  endtask

  // One cycle: drive after rising edge, compare at falling edge, then advance model.
  task automatic step(bit rnd);
    bit e_in_ready, e_out_valid, e_fire, e_done;
    logic [DW-1:0] e_data;
    @(posedge clk); #1;
    req_valid = (req_len_q.size() > 0);
    req_len   = req_valid ? LW'(req_len_q[0]) : '0;
    req_final = req_valid ? req_fin_q[0] : 1'b0;
    if (beat_q.size() > 0) begin
      in_valid = stalled ? 1'b1 : (!rnd || ($urandom % 4 != 0));
      {in_last, in_data} = beat_q[0];
    end else begin
      in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    end
    out_ready = !rnd || ($urandom % 3 != 0);
    @(negedge clk);
    e_in_ready  = (m_st == 1) && out_ready;
    e_out_valid = (m_st == 1) ? in_valid : (m_st == 2);
    e_data      = (m_st == 1) ? in_data : '0;
    e_fire      = e_out_valid && out_ready;
    e_done      = e_fire && (m_left == 1);
    chk("R1 req_ready", req_ready, m_st == 0);
    chk(m_st == 2 ? "R4 in_ready" : "R2 in_ready", in_ready, e_in_ready);
    chk(m_st == 0 ? "R1 out_valid" : "R2 out_valid", out_valid, e_out_valid);
    if (e_out_valid) chk(m_st == 2 ? "R3 out_data" : "R2 out_data", out_data, e_data);
    chk("R7 done_pulse", done_pulse, e_done);
    chk("R8 done_final", done_final, e_done && m_flag);
    if (out_valid && out_ready && !in_ready) pad_cnt++;
    if (done_pulse) done_cnt++;
    stalled = in_valid && !e_in_ready;
    if (in_valid && e_in_ready) void'(beat_q.pop_front());
    if (m_st == 0) begin
      if (req_valid) begin
        if (req_len_q[0] != 0) begin
          m_st = 1; m_left = req_len_q[0]; m_flag = req_fin_q[0];
        end
        void'(req_len_q.pop_front()); void'(req_fin_q.pop_front());
      end
    end else if (e_fire) begin
      if (m_left == 1) m_st = 0;
      else begin
        m_left--;
        if (m_st == 1 && in_last) m_st = 2;
      end
    end
  endtask

  task automatic run(int max_cyc, bit rnd);
    int n = 0;
    pad_cnt = 0; done_cnt = 0;
    while (!(req_len_q.size() == 0 && m_st == 0)) begin
      if (n >= max_cyc) begin
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=<%0d", n, max_cyc);
        model_reset();
        break;
      end
      step(rnd);
      n++;
    end
    step(rnd);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 in_ready", in_ready, 0);
    chk("R9 out_valid", out_valid, 0);
    chk("R9 done_pulse", done_pulse, 0);
    @(posedge clk); #1 rst = 1'b0;

    // R3 short packet padded: len 5, packet 2 -> 3 zero beats
    push_req(5, 1); push_pkt(2, 16'h100);
    run(200, 0);
    chk("R3 pad beats", pad_cnt, 3);
    chk("R7 done count", done_cnt, 1);

    // R5 last on final beat: no padding
    push_req(3, 0); push_pkt(3, 16'h200);
    run(200, 0);
    chk("R5 pad beats", pad_cnt, 0);
    chk("R5 done count", done_cnt, 1);

    // R6 length runs out first; remainder feeds next transfer (3 fwd + 1 pad)
    push_req(2, 0); push_req(4, 1); push_pkt(5, 16'h300);
    run(200, 0);
    chk("R6 pad beats", pad_cnt, 1);
    chk("R6 done count", done_cnt, 2);
    chk("R6 input drained", beat_q.size(), 0);

    // R1 zero-length request ignored
    push_req(0, 1);
    run(20, 0);
    chk("R1 zero len done", done_cnt, 0);
    chk("R1 zero len idle", req_ready, 1);

    // Random stall patterns on both sides
    for (int k = 0; k < 40; k++) begin
      int len = 1 + ($urandom % 9);
      int pk  = 1 + ($urandom % 9);
      push_req(len, k[0]);
      push_pkt(pk, k * 32);
      run(2000, 1);
      beat_q.delete(); stalled = 0;
    end

    // R9 reset mid-transfer
    push_req(6, 1); push_pkt(6, 16'h500);
    repeat (3) step(0);
    @(posedge clk); #1 rst = 1'b1; in_valid = 1'b0; req_valid = 1'b0;
    model_reset();
    @(negedge clk);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk("R9 mid in_ready", in_ready, 0);
    chk("R9 mid out_valid", out_valid, 0);
    chk("R9 mid idle", req_ready, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule